// File: doc/BRIEF.md
# Dual-Bus Transport-Triggered Processor Core

This block is a small processor with no opcodes. Each 32-bit instruction word holds two move slots. Each slot copies a value from an output port of one functional unit to an input port of another. The two moves issue together, one on each of two internal buses. Writing to some input ports starts work in the unit that owns them. Loading an accumulator, adding to it, storing to memory, starting a memory read and changing the flow of control all happen this way.

The core has five units: a 32-entry register file, a value unit for constants and inline immediates, an accumulating arithmetic unit, a memory unit that drives a single synchronous data-memory port, and a control unit with jump, call and return plus versions that depend on the accumulator. Instructions come from a synchronous-read instruction memory. The fetch sequence reads the instruction word and then any immediate words that follow it, executes both moves, and moves on. When a move's source has no valid data yet, the whole instruction waits.

Top module: `tta_core`

## Requirements
- R1: While reset is high, and in the first cycle after it, `imem_addr` is 0 and `dmem_en`/`dmem_we` are low. Execution starts at instruction address 0.
- R2: Slot 0 is bits [31:16] and slot 1 is bits [15:0]. Within a slot, the source unit is [15:13], the source port [12:8], the destination unit [7:5] and the destination port [4:0]. Unit 0 is the register file: ports 0..31 read and write registers 0..31.
- R3: Unit 1 is a source only: port 0 gives 0, port 1 gives 1 and port 2 gives an immediate word. When both slots use port 2, slot 0 takes the first word after the instruction and slot 1 the second. When only one slot uses it, that slot takes the first word. The next instruction follows all consumed words.
- R4: Unit 2 is the arithmetic unit. Destination port 0 loads the accumulator, 1 adds, 2 subtracts, 3 multiplies (low bits kept) and 4 divides, which always yields 0. Source port 0 reads the accumulator. When both slots write different ports of this unit, slot 0's operation is applied first and slot 1's to its result.
- R5: Unit 3 is the memory unit. Destination port 0 sets the store address. Port 1 writes data to memory with a one-cycle `dmem_en`+`dmem_we` pulse, using a store address written in the same instruction if there is one. Port 2 starts a read (a one-cycle `dmem_en` pulse with `dmem_we` low). Source port 0 gives the read data.
- R6: A move whose source is the memory read-data port stalls the instruction until the data has been captured, `RD_DELAY` cycles after the read request. After a new read starts, the old data is no longer valid.
- R7: Both moves read their sources before either destination is written. When both slots name the same destination, only slot 1's move takes effect.
- R8: Unit 4 is the control unit. Port 0 jumps to the moved value. Port 1 calls: it jumps and pushes the address after the instruction and its immediates. Port 2 returns to the last pushed address. Ports 3, 4 and 5 are the same three operations, done only when the accumulator was nonzero before the instruction. A taken transfer skips the sequential path.
- R9: The return stack holds `STACK_DEPTH` (8) addresses. Nested calls eight deep return in last-in, first-out order.
- R10: A source on an unassigned unit or port reads as 0. A write to an unassigned unit or port changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IAW | Instruction memory read address (registered) |
| imem_rdata | input | 32 | Instruction memory read data, valid the cycle after the address is sampled |
| dmem_en | output | 1 | Data memory access strobe |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | DAW | Data memory address |
| dmem_wdata | output | DW | Data memory write data |
| dmem_rdata | input | DW | Data memory read data, registered by the memory |

## Verification
The bench builds the core with `RD_DELAY` = 12. At that value a read-data move fetched right after its read request must stall for several cycles. A stale value would then show up as a wrong stored word. The return stack stays at its depth of 8, and the program nests calls eight deep so that every entry is in use at once. Data widths stay at 32 bits and address widths at 10, which is enough room for subroutines placed at fixed high addresses and a trap region that catches wrongly taken branches.

// File: rtl/tta_pkg.sv
package tta_pkg;
  // unit numbers (3-bit unit field)
  localparam logic [2:0] U_REG = 3'd0;
  localparam logic [2:0] U_VAL = 3'd1;
  localparam logic [2:0] U_ALU = 3'd2;
  localparam logic [2:0] U_MEM = 3'd3;
  localparam logic [2:0] U_CTL = 3'd4;

  // value unit sources
  localparam logic [4:0] P_ZERO = 5'd0;
  localparam logic [4:0] P_ONE  = 5'd1;
  localparam logic [4:0] P_IMM  = 5'd2;

  // arithmetic unit ports
  localparam logic [4:0] A_LOAD = 5'd0;
  localparam logic [4:0] A_ADD  = 5'd1;
  localparam logic [4:0] A_SUB  = 5'd2;
  localparam logic [4:0] A_MUL  = 5'd3;
  localparam logic [4:0] A_DIV  = 5'd4;
  localparam logic [4:0] A_RES  = 5'd0;

  // memory unit ports
  localparam logic [4:0] M_STADDR = 5'd0;
  localparam logic [4:0] M_STDATA = 5'd1;
  localparam logic [4:0] M_RDADDR = 5'd2;
  localparam logic [4:0] M_RDVAL  = 5'd0;

  // control unit ports
  localparam logic [4:0] C_RET   = 5'd2;
  localparam logic [4:0] C_JNZ   = 5'd3;
  localparam logic [4:0] C_RETNZ = 5'd5;

  localparam logic [1:0] K_JMP  = 2'd0;
  localparam logic [1:0] K_CALL = 2'd1;
  localparam logic [1:0] K_RET  = 2'd2;

  typedef struct packed {
    logic [2:0] su;
    logic [4:0] sp;
    logic [2:0] du;
    logic [4:0] dp;
  } move_t;

  typedef enum logic [1:0] {S_REQ, S_WAIT, S_CAP, S_EXEC} fetch_state_t;
endpackage

// File: rtl/tta_regfile.sv
module tta_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic [4:0]    ra0,
  input  logic [4:0]    ra1,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1,
  input  logic          we0,
  input  logic [4:0]    wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [4:0]    wa1,
  input  logic [DW-1:0] wd1
);
  logic [DW-1:0] rf [NREG];

  // slot 1 write is placed last so it wins on an address clash
  always_ff @(posedge clk) begin
    if (we0 && int'(wa0) < NREG) rf[wa0] <= wd0;
    if (we1 && int'(wa1) < NREG) rf[wa1] <= wd1;
  end

  assign rd0 = (int'(ra0) < NREG) ? rf[ra0] : '0;
  assign rd1 = (int'(ra1) < NREG) ? rf[ra1] : '0;
endmodule

// File: rtl/tta_accum.sv
module tta_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en0,
  input  logic [4:0]    port0,
  input  logic [DW-1:0] val0,
  input  logic          en1,
  input  logic [4:0]    port1,
  input  logic [DW-1:0] val1,
  output logic [DW-1:0] acc
);
  import tta_pkg::*;

  logic [DW-1:0] acc_q, mid, fin;

  function automatic logic [DW-1:0] apply(logic [DW-1:0] a, logic en,
                                          logic [4:0] p, logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = a;
    if (en) begin
      case (p)
        A_LOAD:  r = v;
        A_ADD:   r = a + v;
        A_SUB:   r = a - v;
        A_MUL:   r = a * v;
        A_DIV:   r = '0;
        default: r = a;
      endcase
    end
    return r;
  endfunction

  // slot 0 operation first, slot 1 chained on its result
  always_comb begin
    mid = apply(acc_q, en0, port0, val0);
    fin = apply(mid, en1, port1, val1);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= fin;
  end

  assign acc = acc_q;
endmodule

// File: rtl/tta_callstack.sv
module tta_callstack #(
  parameter int AW    = 10,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top
);
  localparam int SPW = $clog2(DEPTH);

  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (push) mem[sp_q] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + SPW'(1);
    else if (pop)  sp_q <= sp_q - SPW'(1);
  end

  assign top = mem[sp_q - SPW'(1)];
endmodule

// File: rtl/tta_core.sv
module tta_core #(
  parameter int DW          = 32,
  parameter int IAW         = 10,
  parameter int DAW         = 10,
  parameter int NREG        = 32,
  parameter int STACK_DEPTH = 8,
  parameter int RD_DELAY    = 2
) (
  input  logic           clk,
  input  logic           rst,
  output logic [IAW-1:0] imem_addr,
  input  logic [31:0]    imem_rdata,
  output logic           dmem_en,
  output logic           dmem_we,
  output logic [DAW-1:0] dmem_addr,
  output logic [DW-1:0]  dmem_wdata,
  input  logic [DW-1:0]  dmem_rdata
);
  import tta_pkg::*;

  localparam int CW = $clog2(RD_DELAY + 1);

  fetch_state_t   state_q;
  logic [IAW-1:0] pc_q, fptr_q, imem_addr_q;
  logic [1:0]     widx_q;
  logic [31:0]    instr_q;
  logic [DW-1:0]  imm_a_q, imm_b_q;

  logic           dmem_en_q, dmem_we_q;
  logic [DAW-1:0] dmem_addr_q, st_addr_q, st_addr_nx, rd_a;
  logic [DW-1:0]  dmem_wdata_q, rd_word_q, st_data;
  logic [CW-1:0]  rd_cnt_q;
  logic           rd_valid_q;

  move_t m0, m1, c0, c1;
  logic  u0, u1, stall, fire, same_dst, eff0, eff1, exec_stall;
  logic [1:0] n_imm, cap_need;
  logic [DW-1:0] rd0, rd1, acc, v0, v1;
  logic [IAW-1:0] seq_pc, stack_top, target, next_pc;

  function automatic logic is_imm(move_t m);
    return m.su == U_VAL && m.sp == P_IMM;
  endfunction

  function automatic logic [DW-1:0] pick(move_t m, logic [DW-1:0] rv, logic [DW-1:0] iv,
                                         logic [DW-1:0] a, logic [DW-1:0] rw);
    logic [DW-1:0] r;
    r = '0;
    case (m.su)
      U_REG: r = rv;
      U_VAL: r = (m.sp == P_ONE) ? DW'(1) : (m.sp == P_IMM) ? iv : '0;
      U_ALU: r = (m.sp == A_RES) ? a : '0;
      U_MEM: r = (m.sp == M_RDVAL) ? rw : '0;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic hit(logic en, move_t m, logic [2:0] u, logic [4:0] p);
    return en && m.du == u && m.dp == p;
  endfunction

  function automatic logic [2:0] ctl_dec(logic en, move_t m, logic cond);
    logic       tk;
    logic [1:0] k;
    tk = 1'b0;
    k  = K_JMP;
    if (en && m.du == U_CTL) begin
      if (m.dp <= C_RET) begin
        tk = 1'b1;
        k  = m.dp[1:0];
      end else if (m.dp <= C_RETNZ) begin
        tk = cond;
        k  = 2'(m.dp - C_JNZ);
      end
    end
    return {tk, k};
  endfunction

  // ---------------- decode ----------------
  assign m0 = move_t'(instr_q[31:16]);
  assign m1 = move_t'(instr_q[15:0]);
  assign c0 = move_t'(imem_rdata[31:16]);
  assign c1 = move_t'(imem_rdata[15:0]);
  assign u0 = is_imm(m0);
  assign u1 = is_imm(m1);
  assign n_imm    = {1'b0, u0} + {1'b0, u1};
  assign cap_need = {1'b0, is_imm(c0)} + {1'b0, is_imm(c1)};

  tta_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .ra0(m0.sp), .ra1(m1.sp), .rd0(rd0), .rd1(rd1),
    .we0(eff0 && m0.du == U_REG), .wa0(m0.dp), .wd0(v0),
    .we1(eff1 && m1.du == U_REG), .wa1(m1.dp), .wd1(v1)
  );

  // sources are all read from pre-instruction state
  assign v0 = pick(m0, rd0, imm_a_q, acc, rd_word_q);
  assign v1 = pick(m1, rd1, u0 ? imm_b_q : imm_a_q, acc, rd_word_q);

  assign stall = ((m0.su == U_MEM && m0.sp == M_RDVAL) ||
                  (m1.su == U_MEM && m1.sp == M_RDVAL)) && !rd_valid_q;
  assign fire       = (state_q == S_EXEC) && !stall;
  assign exec_stall = (state_q == S_EXEC) && stall;
  assign same_dst   = (m0.du == m1.du) && (m0.dp == m1.dp);
  assign eff0       = fire && !same_dst;
  assign eff1       = fire;

  tta_accum #(.DW(DW)) u_alu (
    .clk(clk), .rst(rst),
    .en0(eff0 && m0.du == U_ALU), .port0(m0.dp), .val0(v0),
    .en1(eff1 && m1.du == U_ALU), .port1(m1.dp), .val1(v1),
    .acc(acc)
  );

  // ---------------- memory unit ----------------
  logic sa0, sa1, sv0, sv1, ra0w, ra1w, st_go, rd_go;
  assign sa0  = hit(eff0, m0, U_MEM, M_STADDR);
  assign sa1  = hit(eff1, m1, U_MEM, M_STADDR);
  assign sv0  = hit(eff0, m0, U_MEM, M_STDATA);
  assign sv1  = hit(eff1, m1, U_MEM, M_STDATA);
  assign ra0w = hit(eff0, m0, U_MEM, M_RDADDR);
  assign ra1w = hit(eff1, m1, U_MEM, M_RDADDR);
  assign st_addr_nx = sa1 ? DAW'(v1) : sa0 ? DAW'(v0) : st_addr_q;
  assign st_go      = sv0 || sv1;
  assign st_data    = sv1 ? v1 : v0;
  assign rd_go      = ra0w || ra1w;
  assign rd_a       = ra1w ? DAW'(v1) : DAW'(v0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dmem_en_q    <= 1'b0;
      dmem_we_q    <= 1'b0;
      dmem_addr_q  <= '0;
      dmem_wdata_q <= '0;
      st_addr_q    <= '0;
      rd_cnt_q     <= '0;
      rd_valid_q   <= 1'b0;
      rd_word_q    <= '0;
    end else begin
      dmem_en_q <= st_go || rd_go;
      dmem_we_q <= st_go;
      st_addr_q <= st_addr_nx;
      if (st_go) begin
        dmem_addr_q  <= st_addr_nx;
        dmem_wdata_q <= st_data;
      end else if (rd_go) begin
        dmem_addr_q <= rd_a;
      end
      if (rd_go && !st_go) begin
        rd_cnt_q   <= CW'(RD_DELAY);
        rd_valid_q <= 1'b0;
      end else if (rd_cnt_q != '0) begin
        rd_cnt_q <= rd_cnt_q - CW'(1);
        if (rd_cnt_q == CW'(1)) begin
          rd_word_q  <= dmem_rdata;
          rd_valid_q <= 1'b1;
        end
      end
    end
  end

  // ---------------- control unit ----------------
  logic [2:0] d0, d1;
  logic       taken, push, pop;
  logic [1:0] kind;
  logic [DW-1:0] tval;
  assign d0     = ctl_dec(eff0, m0, acc != '0);
  assign d1     = ctl_dec(eff1, m1, acc != '0);
  assign taken  = d0[2] || d1[2];
  assign kind   = d1[2] ? d1[1:0] : d0[1:0];
  assign tval   = d1[2] ? v1 : v0;
  assign push   = taken && kind == K_CALL;
  assign pop    = taken && kind == K_RET;
  assign seq_pc = pc_q + IAW'(1) + IAW'(n_imm);
  assign target = (kind == K_RET) ? stack_top : IAW'(tval);
  assign next_pc = taken ? target : seq_pc;

  tta_callstack #(.AW(IAW), .DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_val(seq_pc), .top(stack_top)
  );

  // ---------------- fetch sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_REQ;
      pc_q        <= '0;
      fptr_q      <= '0;
      imem_addr_q <= '0;
      widx_q      <= '0;
      instr_q     <= '0;
      imm_a_q     <= '0;
      imm_b_q     <= '0;
    end else begin
      case (state_q)
        S_REQ: begin
          imem_addr_q <= fptr_q;
          state_q     <= S_WAIT;
        end
        S_WAIT: state_q <= S_CAP;
        S_CAP: begin
          case (widx_q)
            2'd0: begin
              instr_q <= imem_rdata;
              if (cap_need != 2'd0) begin
                widx_q  <= 2'd1;
                fptr_q  <= pc_q + IAW'(1);
                state_q <= S_REQ;
              end else begin
                state_q <= S_EXEC;
              end
            end
            2'd1: begin
              imm_a_q <= DW'(imem_rdata);
              if (n_imm == 2'd2) begin
                widx_q  <= 2'd2;
                fptr_q  <= pc_q + IAW'(2);
                state_q <= S_REQ;
              end else begin
                state_q <= S_EXEC;
              end
            end
            default: begin
              imm_b_q <= DW'(imem_rdata);
              state_q <= S_EXEC;
            end
          endcase
        end
        S_EXEC: begin
          if (fire) begin
            pc_q    <= next_pc;
            fptr_q  <= next_pc;
            widx_q  <= '0;
            state_q <= S_REQ;
          end
        end
        default: state_q <= S_REQ;
      endcase
    end
  end

  assign imem_addr  = imem_addr_q;
  assign dmem_en    = dmem_en_q;
  assign dmem_we    = dmem_we_q;
  assign dmem_addr  = dmem_addr_q;
  assign dmem_wdata = dmem_wdata_q;
endmodule

// File: rtl/tta_core_chk.sv
module tta_core_chk #(
  parameter int IAW = 10
) (
  input logic           clk,
  input logic           rst,
  input logic [IAW-1:0] imem_addr,
  input logic           dmem_en,
  input logic           dmem_we,
  input logic           rd_valid,
  input logic           exec_stall
);
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> imem_addr == '0);

  p_store_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> dmem_en);

  p_access_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_en |=> !dmem_en);

  p_read_clears_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (dmem_en && !dmem_we) |=> !rd_valid);

  p_stall_holds_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    exec_stall |=> $stable(imem_addr));

  p_stall_no_access_r6: assert property (@(posedge clk) disable iff (rst)
    exec_stall |-> !dmem_en);
endmodule

bind tta_core tta_core_chk #(.IAW(IAW)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .dmem_en(dmem_en),
  .dmem_we(dmem_we), .rd_valid(rd_valid_q), .exec_stall(exec_stall)
);

// File: tb/tta_core_tb.sv
module tta_core_tb_top;
  localparam int DW = 32;
  localparam int IAW = 10;
  localparam int DAW = 10;
  localparam int UR = 0, UV = 1, UA = 2, UM = 3, UC = 4, UX = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IAW-1:0] imem_addr;
  logic [31:0]    imem_rdata;
  logic           dmem_en, dmem_we;
  logic [DAW-1:0] dmem_addr;
  logic [DW-1:0]  dmem_wdata, dmem_rdata;

  always #10 clk = ~clk;

  tta_core #(.DW(DW), .IAW(IAW), .DAW(DAW), .RD_DELAY(12)) dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_en(dmem_en), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  logic [31:0] im [1024];
  logic [31:0] dm [1024];
  always @(posedge clk) imem_rdata <= im[imem_addr];
  always @(posedge clk) if (dmem_en) begin
    if (dmem_we) dm[dmem_addr] <= dmem_wdata;
    else         dmem_rdata <= dm[dmem_addr];
  end

  typedef struct { int addr; logic [31:0] data; string req; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0, p = 0;

  function automatic logic [15:0] mv(int su, int sp, int du, int dp);
    return {3'(su), 5'(sp), 3'(du), 5'(dp)};
  endfunction
  localparam logic [15:0] NOP = 16'hE0E0;

  task automatic emit(logic [31:0] w); im[p] = w; p++; endtask
  task automatic ins(logic [15:0] a, logic [15:0] b); emit({a, b}); endtask
  task automatic push_exp(int a, logic [31:0] d, string r);
    exp_t e; e.addr = a; e.data = d; e.req = r; sb.push_back(e);
  endtask
  task automatic st_imm(int a, logic [31:0] d, bit ex, string r);
    ins(mv(UV,2,UM,0), mv(UV,2,UM,1)); emit(a); emit(d);
    if (ex) push_exp(a, d, r);
  endtask
  task automatic st_reg(int a, int rg, logic [31:0] d, string r);
    ins(mv(UV,2,UM,0), mv(UR,rg,UM,1)); emit(a); push_exp(a, d, r);
  endtask
  task automatic st_acc(int a, logic [31:0] d, string r);
    ins(mv(UV,2,UM,0), mv(UA,0,UM,1)); emit(a); push_exp(a, d, r);
  endtask
  task automatic halt();
    int here; here = p; ins(mv(UV,2,UC,0), NOP); emit(here);
  endtask
  task automatic chk(bit ok, string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", r, got, exp);
    end
  endtask

  // scoreboard monitor: compare every data-memory write
  always @(negedge clk) if (!rst && dmem_en && dmem_we) begin
    if (sb.size() == 0) begin
      chk(1'b0, "unexpected store", {22'd0, dmem_addr}, 32'hFFFF_FFFF);
    end else begin
      exp_t e;
      e = sb.pop_front();
      chk(int'(dmem_addr) == e.addr, e.req, {22'd0, dmem_addr}, e.addr);
      chk(dmem_wdata === e.data, e.req, dmem_wdata, e.data);
    end
  end

  initial begin
    int t, cyc;
    for (int i = 0; i < 1024; i++) begin im[i] = {NOP, NOP}; dm[i] = '0; end
    // trap region for wrongly taken transfers
    p = 900; st_imm(199, 32'hDEAD, 1'b0, ""); halt();
    // nested chain for R9: D_k at 700+10k
    for (int k = 0; k < 8; k++) begin
      p = 700 + 10 * k;
      if (k < 7) begin ins(mv(UV,2,UC,1), NOP); emit(700 + 10 * (k + 1)); end
      st_imm(130 + k, k, 1'b0, "");
      ins(mv(UV,0,UC,2), NOP);
    end
    // A at 800, B at 850, C at 870
    p = 800; st_imm(120, 1, 1'b0, ""); ins(mv(UV,2,UC,1), NOP); emit(850);
    st_imm(122, 3, 1'b0, ""); ins(mv(UV,0,UC,2), NOP);
    p = 850; ins(mv(UV,0,UC,5), NOP); st_imm(121, 2, 1'b0, ""); ins(mv(UV,0,UC,2), NOP);
    p = 870; st_imm(124, 5, 1'b0, ""); ins(mv(UV,0,UC,5), NOP); st_imm(198, 32'hBAD, 1'b0, "");

    p = 0;
    ins(mv(UV,2,UR,1), mv(UV,2,UR,2)); emit(100); emit(7);          // R3 two immediates
    ins(mv(UR,1,UM,0), mv(UR,2,UM,1)); push_exp(100, 7, "R2/R5");   // same-instr addr forward
    ins(mv(UV,2,UR,3), mv(UV,1,UR,4)); emit(5);
    ins(mv(UV,0,UR,5), mv(UV,2,UR,6)); emit(9);                     // slot1-only immediate
    ins(mv(UR,3,UA,0), mv(UR,6,UA,1)); st_acc(101, 14, "R4 load+add");
    ins(mv(UR,2,UA,3), mv(UR,4,UA,2)); st_acc(102, 97, "R4 mul+sub");
    ins(mv(UR,3,UA,4), NOP);           st_acc(103, 0, "R4 div");
    st_reg(104, 4, 1, "R3 one"); st_reg(105, 5, 0, "R3 zero"); st_reg(106, 6, 9, "R3 slot1 imm");
    ins(mv(UR,1,UR,2), mv(UR,2,UR,1));                              // swap
    st_reg(107, 1, 7, "R7 swap"); st_reg(108, 2, 100, "R7 swap");
    ins(mv(UR,3,UR,7), mv(UR,6,UR,7)); st_reg(109, 7, 9, "R7 same dest");
    ins(mv(UR,6,UA,0), NOP);
    ins(mv(UR,3,UA,0), mv(UA,0,UR,8));
    st_reg(110, 8, 9, "R7 old acc"); st_acc(111, 5, "R7 acc");
    ins(mv(UV,2,UR,9), NOP); emit(77);
    ins(mv(5,3,UR,9), mv(UR,3,UA,7));
    st_reg(112, 9, 0, "R10 src"); st_acc(113, 5, "R10 dst");
    ins(mv(UV,2,UR,31), NOP); emit(32'h1234_5678); st_reg(114, 31, 32'h1234_5678, "R2 r31");
    ins(mv(UV,2,UM,2), NOP); emit(101);
    ins(mv(UM,0,UR,10), NOP); st_reg(115, 10, 14, "R6 read");
    ins(mv(UV,2,UM,2), mv(UV,2,UM,0)); emit(100); emit(116);
    ins(mv(UM,0,UM,1), NOP); push_exp(116, 7, "R6 stall");
    t = p + 5; ins(mv(UV,2,UC,0), NOP); emit(t); st_imm(198, 32'hBAD, 1'b0, "");
    st_imm(117, 1, 1'b1, "R8 jump");
    t = p + 5; ins(mv(UV,2,UC,3), NOP); emit(t); st_imm(198, 32'hBAD, 1'b0, "");
    st_imm(118, 2, 1'b1, "R8 jnz taken");
    ins(mv(UV,0,UA,0), NOP);
    ins(mv(UV,1,UA,0), mv(UV,2,UC,3)); emit(900);                   // old acc 0: not taken
    st_imm(119, 3, 1'b1, "R8 jnz old acc");
    ins(mv(UV,0,UA,0), NOP);
    ins(mv(UV,2,UC,1), NOP); emit(800);
    push_exp(120, 1, "R8 call"); push_exp(121, 2, "R8 nested retnz");
    push_exp(122, 3, "R8 return");
    st_imm(123, 4, 1'b1, "R8 return main");
    ins(mv(UV,1,UA,0), NOP);
    ins(mv(UV,2,UC,4), NOP); emit(870); push_exp(124, 5, "R8 callnz");
    st_imm(125, 6, 1'b1, "R8 retnz taken");
    ins(mv(UV,0,UA,0), NOP);
    ins(mv(UV,2,UC,4), NOP); emit(900);
    st_imm(126, 7, 1'b1, "R8 callnz not taken");
    ins(mv(UV,2,UC,1), NOP); emit(700);
    for (int k = 7; k >= 0; k--) push_exp(130 + k, k, "R9 depth");
    st_imm(140, 8, 1'b1, "R9 final return");
    halt();

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == '0, "R1 imem_addr", {22'd0, imem_addr}, 0);
    chk(!dmem_en && !dmem_we, "R1 dmem idle", {30'd0, dmem_en, dmem_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(imem_addr == '0, "R1 first fetch", {22'd0, imem_addr}, 0);

    cyc = 0;
    while (sb.size() != 0 && cyc < 20000) begin @(posedge clk); cyc++; end
    if (cyc >= 20000) chk(1'b0, "watchdog", sb.size(), 0);
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(sb.size() == 0, "all stores seen", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule